// File: doc/BRIEF.md
# SIMD Partition Run/System Mode Controller

This block holds the mode state for every board in one synchronized SIMD partition, together with the root-side logic that combines their local signals. Each board is either in system mode or in run mode. In system mode the host may reach every memory and register, and the sequencer is idle. In run mode the user program executes and host access is refused.

A board never changes mode on its own. Any of its halt causes raises a local halt request. The causes are a HALT instruction, an exception that is not masked, or a host stop. The root ORs all the local requests, plus a host hold line, into one global halt flag. Every board leaves run mode when that flag goes active. Every board resumes when the flag is released. The root also reduces the if-status, network-busy and clock-stretch signals of all boards. The if-status result is what run-mode conditional branches test.

The number of boards (up to 16) and the exception vector width are parameters. One instance models the whole partition.

Top module: `simd_mode_ctrl`

## Requirements
- R1: While reset is asserted, every board is in system mode (`run_mode_o` bit = 0), every halt request is 0, `glb_halt_o` = 1, `glb_clk_en_o` = 1, and `glb_ifstatus_o` and `glb_netbusy_o` are 0.
- R2: `glb_halt_o` is a register. It takes the OR of all `halt_req_o` bits and `host_hold_i`, one clock after they are sampled.
- R3: A board in run mode that samples `glb_halt_o` = 1 is in system mode on the next clock. Since all boards see the same flag, all boards change mode in the same cycle.
- R4: A board in system mode that samples `glb_halt_o` = 0 is in run mode on the next clock.
- R5: In run mode, `halt_instr_i` for a board sets that board's `halt_req_o` on the next clock.
- R6: Exception bit i of board b sits at flat index b*EXC_W+i of `exc_raw_i`. It raises the halt request (run mode, next clock) only when bit i of that board's mask is 1. The mask resets to all ones.
- R7: A mask write (`exc_mask_we_i` bit b, data `exc_mask_data_i`) takes effect only in system mode. In run mode the write is ignored.
- R8: In run mode, `host_stop_i` sets the board's halt request on the next clock. In system mode, a HALT instruction, a host stop or an exception leaves the halt request at 0.
- R9: A board's halt request stays set until the board has been sampled in system mode. It then clears on the next clock.
- R10: `host_grant_o` bit b equals `host_req_i` bit b while board b is in system mode. It is 0 in run mode. It is combinational.
- R11: `glb_ifstatus_o` is the registered OR of `ifstatus_i`. `branch_take_o` bit b is `branch_req_i` bit b AND run mode AND `glb_ifstatus_o`, combinational.
- R12: `glb_netbusy_o` is the registered OR of `net_busy_i`.
- R13: `glb_clk_en_o` is registered. It is 0 one clock after any `clk_stretch_i` bit is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_instr_i | input | NB | Sequencer reached a HALT instruction, per board |
| exc_raw_i | input | NB*EXC_W | Raw exception bits, board-major |
| exc_mask_we_i | input | NB | Mask write strobe, per board |
| exc_mask_data_i | input | EXC_W | Mask write data (1 = exception enabled) |
| host_stop_i | input | NB | Host stop request, per board |
| host_hold_i | input | 1 | Host keeps the partition halted |
| host_req_i | input | NB | Host access request, per board |
| host_grant_o | output | NB | Host access granted, per board |
| ifstatus_i | input | NB | Local if-status, per board |
| branch_req_i | input | NB | Conditional branch request, per board |
| branch_take_o | output | NB | Branch taken, per board |
| net_busy_i | input | NB | Local network busy, per board |
| clk_stretch_i | input | NB | Clock stretch request, per board |
| run_mode_o | output | NB | 1 = run mode, per board |
| halt_req_o | output | NB | Local halt request, per board |
| glb_halt_o | output | 1 | Global halt flag |
| glb_ifstatus_o | output | 1 | Global if-status |
| glb_netbusy_o | output | 1 | Global network busy |
| glb_clk_en_o | output | 1 | Global clock enable |

## Verification
All 16 patterns of the four-board reduction inputs are swept. This separates an OR from an AND, and a per-board slice from the whole vector. Host request patterns are swept in system mode and applied again in run mode, which shows the gating. Full halt round trips are driven with one cause at a time: a HALT instruction, an enabled exception under a written mask, an exception under the reset mask, a host stop, and a mix of causes. Each round trip checks the exact cycle of every register step, and that all boards follow together. Halt causes are also applied in system mode, and mask writes in run mode, to show that they are ignored.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic {
    MODE_SYS = 1'b0,
    MODE_RUN = 1'b1
  } mode_e;
endpackage

// File: rtl/smc_mode_fsm.sv
module smc_mode_fsm
  import smc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  glb_halt_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: if (glb_halt_i)  mode_d = MODE_SYS;
      MODE_SYS: if (!glb_halt_i) mode_d = MODE_RUN;
      default:                   mode_d = MODE_SYS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SYS;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/smc_halt_cause.sv
module smc_halt_cause #(
  parameter int EXC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_run_i,
  input  logic             halt_instr_i,
  input  logic             host_stop_i,
  input  logic [EXC_W-1:0] exc_i,
  input  logic             mask_we_i,
  input  logic [EXC_W-1:0] mask_d_i,
  output logic             halt_req_o
);
  logic [EXC_W-1:0] mask_q;
  logic             mask_en;
  logic             cause;
  logic             req_q, req_d;

  // host may only reprogram the mask while the board is halted
  assign mask_en = mask_we_i && !in_run_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d_i;
  end

  assign cause = halt_instr_i || host_stop_i || (|(exc_i & mask_q));

  always_comb begin
    req_d = req_q;
    if (!in_run_i)  req_d = 1'b0;
    else if (cause) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign halt_req_o = req_q;
endmodule

// File: rtl/smc_root_reduce.sv
module smc_root_reduce #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] halt_req_i,
  input  logic          host_hold_i,
  input  logic [NB-1:0] ifstatus_i,
  input  logic [NB-1:0] net_busy_i,
  input  logic [NB-1:0] stretch_i,
  output logic          glb_halt_o,
  output logic          glb_ifstatus_o,
  output logic          glb_netbusy_o,
  output logic          glb_clk_en_o
);
  logic halt_d, ifs_d, nb_d, cen_d;

  always_comb begin
    halt_d = (|halt_req_i) || host_hold_i;
    ifs_d  = |ifstatus_i;
    nb_d   = |net_busy_i;
    cen_d  = ~(|stretch_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_halt_o     <= 1'b1;
      glb_ifstatus_o <= 1'b0;
      glb_netbusy_o  <= 1'b0;
      glb_clk_en_o   <= 1'b1;
    end else begin
      glb_halt_o     <= halt_d;
      glb_ifstatus_o <= ifs_d;
      glb_netbusy_o  <= nb_d;
      glb_clk_en_o   <= cen_d;
    end
  end
endmodule

// File: rtl/simd_mode_ctrl.sv
module simd_mode_ctrl
  import smc_pkg::*;
#(
  parameter int NB    = 4,
  parameter int EXC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NB-1:0]      halt_instr_i,
  input  logic [NB*EXC_W-1:0] exc_raw_i,
  input  logic [NB-1:0]      exc_mask_we_i,
  input  logic [EXC_W-1:0]   exc_mask_data_i,
  input  logic [NB-1:0]      host_stop_i,
  input  logic               host_hold_i,
  input  logic [NB-1:0]      host_req_i,
  output logic [NB-1:0]      host_grant_o,
  input  logic [NB-1:0]      ifstatus_i,
  input  logic [NB-1:0]      branch_req_i,
  output logic [NB-1:0]      branch_take_o,
  input  logic [NB-1:0]      net_busy_i,
  input  logic [NB-1:0]      clk_stretch_i,
  output logic [NB-1:0]      run_mode_o,
  output logic [NB-1:0]      halt_req_o,
  output logic               glb_halt_o,
  output logic               glb_ifstatus_o,
  output logic               glb_netbusy_o,
  output logic               glb_clk_en_o
);
  localparam int MAX_NB = 16;

  initial begin
    if (NB < 1 || NB > MAX_NB) $error("NB out of range");
  end

  for (genvar b = 0; b < NB; b++) begin : g_board
    mode_e mode;
    logic  in_run;

    smc_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .glb_halt_i (glb_halt_o),
      .mode_o     (mode)
    );

    assign in_run = (mode == MODE_RUN);

    smc_halt_cause #(.EXC_W(EXC_W)) u_cause (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_run_i     (in_run),
      .halt_instr_i (halt_instr_i[b]),
      .host_stop_i  (host_stop_i[b]),
      .exc_i        (exc_raw_i[b*EXC_W +: EXC_W]),
      .mask_we_i    (exc_mask_we_i[b]),
      .mask_d_i     (exc_mask_data_i),
      .halt_req_o   (halt_req_o[b])
    );

    assign run_mode_o[b]    = in_run;
    assign host_grant_o[b]  = host_req_i[b] && !in_run;
    assign branch_take_o[b] = branch_req_i[b] && in_run && glb_ifstatus_o;
  end

  smc_root_reduce #(.NB(NB)) u_root (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_req_i     (halt_req_o),
    .host_hold_i    (host_hold_i),
    .ifstatus_i     (ifstatus_i),
    .net_busy_i     (net_busy_i),
    .stretch_i      (clk_stretch_i),
    .glb_halt_o     (glb_halt_o),
    .glb_ifstatus_o (glb_ifstatus_o),
    .glb_netbusy_o  (glb_netbusy_o),
    .glb_clk_en_o   (glb_clk_en_o)
  );
endmodule

// File: rtl/simd_mode_ctrl_chk.sv
module simd_mode_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] run_mode_o,
  input logic [NB-1:0] halt_req_o,
  input logic [NB-1:0] host_req_i,
  input logic [NB-1:0] host_grant_o,
  input logic [NB-1:0] branch_req_i,
  input logic [NB-1:0] branch_take_o,
  input logic [NB-1:0] clk_stretch_i,
  input logic          glb_halt_o,
  input logic          glb_ifstatus_o,
  input logic          glb_clk_en_o
);
  // R2
  glb_halt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_req_o) |=> glb_halt_o);

  // R3
  boards_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode_o == '0) || (run_mode_o == '1));

  // R13
  stretch_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_stretch_i) |=> !glb_clk_en_o);

  for (genvar b = 0; b < NB; b++) begin : g_chk
    // R3
    enter_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode_o[b] && glb_halt_o) |=> !run_mode_o[b]);

    // R4
    enter_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_mode_o[b] && !glb_halt_o) |=> run_mode_o[b]);

    // R9
    halt_req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_mode_o[b] && halt_req_o[b]) |=> !halt_req_o[b]);

    // R10
    grant_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_grant_o[b] |-> (host_req_i[b] && !run_mode_o[b]));

    // R11
    branch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      branch_take_o[b] |-> (branch_req_i[b] && run_mode_o[b] && glb_ifstatus_o));
  end
endmodule

bind simd_mode_ctrl simd_mode_ctrl_chk #(.NB(NB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .run_mode_o    (run_mode_o),
  .halt_req_o    (halt_req_o),
  .host_req_i    (host_req_i),
  .host_grant_o  (host_grant_o),
  .branch_req_i  (branch_req_i),
  .branch_take_o (branch_take_o),
  .clk_stretch_i (clk_stretch_i),
  .glb_halt_o    (glb_halt_o),
  .glb_ifstatus_o(glb_ifstatus_o),
  .glb_clk_en_o  (glb_clk_en_o)
);

// File: tb/simd_mode_ctrl_test.sv
`timescale 1ns/1ps
module simd_mode_ctrl_test;
  localparam int NB = 4;
  localparam int EW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NB-1:0]    halt_instr, mask_we, host_stop, host_req, ifs, brq, nbusy, stretch;
  logic [NB*EW-1:0] exc;
  logic [EW-1:0]    mask_d;
  logic             hold;
  logic [NB-1:0]    grant, btake, run, hreq;
  logic             ghalt, gifs, gnb, gcen;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  simd_mode_ctrl #(.NB(NB), .EXC_W(EW)) uut (
    .clk(clk), .rst_n(rst_n),
    .halt_instr_i(halt_instr), .exc_raw_i(exc),
    .exc_mask_we_i(mask_we), .exc_mask_data_i(mask_d),
    .host_stop_i(host_stop), .host_hold_i(hold),
    .host_req_i(host_req), .host_grant_o(grant),
    .ifstatus_i(ifs), .branch_req_i(brq), .branch_take_o(btake),
    .net_busy_i(nbusy), .clk_stretch_i(stretch),
    .run_mode_o(run), .halt_req_o(hreq),
    .glb_halt_o(ghalt), .glb_ifstatus_o(gifs),
    .glb_netbusy_o(gnb), .glb_clk_en_o(gcen)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // one full halt round trip; exp = boards whose halt request must rise
  task automatic halt_cycle(input string rq, input logic [NB-1:0] hi,
                            input logic [NB-1:0] st, input logic [NB*EW-1:0] ex,
                            input logic [NB-1:0] exp);
    halt_instr = hi; host_stop = st; exc = ex;
    tick;
    chk({rq, " halt_req set"}, hreq, exp);
    halt_instr = '0; host_stop = '0; exc = '0;
    tick;
    chk("R2 glb_halt rises", ghalt, 1);
    chk("R3 still run one cycle", run, 4'hF);
    tick;
    chk("R3 all boards system", run, 4'h0);
    chk("R9 req held on entry", hreq, exp);
    tick;
    chk("R9 req cleared", hreq, 4'h0);
    chk("R2 glb_halt still high", ghalt, 1);
    tick;
    chk("R2 glb_halt released", ghalt, 0);
    chk("R4 still system", run, 4'h0);
    tick;
    chk("R4 all boards run", run, 4'hF);
  endtask

  initial begin
    rst_n = 1'b0; hold = 1'b1;
    halt_instr = '0; mask_we = '0; host_stop = '0; host_req = '0;
    ifs = '0; brq = '0; nbusy = '0; stretch = '0; exc = '0; mask_d = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 run", run, 0);
    chk("R1 halt_req", hreq, 0);
    chk("R1 glb_halt", ghalt, 1);
    chk("R1 clk_en", gcen, 1);
    chk("R1 ifstatus", gifs, 0);
    chk("R1 netbusy", gnb, 0);
    @(negedge clk); rst_n = 1'b1;
    tick;
    chk("R2 hold keeps halt", ghalt, 1);
    chk("R2 boards stay system", run, 0);

    for (int p = 0; p < 16; p++) begin
      host_req = p[NB-1:0]; #1;
      chk("R10 grant in system", grant, p);
    end
    host_req = '0;

    for (int p = 0; p < 16; p++) begin
      ifs = p[NB-1:0]; nbusy = p[NB-1:0]; stretch = p[NB-1:0];
      tick;
      chk("R11 glb_ifstatus OR", gifs, (p != 0));
      chk("R12 glb_netbusy OR", gnb, (p != 0));
      chk("R13 clk_en", gcen, (p == 0));
    end
    ifs = 4'b0001; nbusy = '0; stretch = '0;
    tick;
    brq = 4'hF; #1;
    chk("R11 no branch in system", btake, 0);
    brq = '0; ifs = '0;

    // R7: write mask of board 1 in system mode -> only bit1 enabled
    mask_we = 4'b0010; mask_d = 3'b010;
    tick;
    mask_we = '0;

    // R8: causes ignored in system mode
    halt_instr = 4'hF; host_stop = 4'hF; exc = '1;
    tick;
    chk("R8 ignored in system", hreq, 0);
    halt_instr = '0; host_stop = '0; exc = '0;
    tick;
    chk("R8 still clear", hreq, 0);

    hold = 1'b0;
    tick;
    chk("R2 release", ghalt, 0);
    chk("R4 not yet run", run, 0);
    tick;
    chk("R4 run", run, 4'hF);

    host_req = 4'hF; #1;
    chk("R10 grant blocked in run", grant, 0);
    host_req = '0;

    ifs = 4'b1000;
    tick;
    brq = 4'b0101; #1;
    chk("R11 branch taken", btake, 4'b0101);
    ifs = '0;
    tick;
    chk("R11 branch not taken", btake, 0);
    brq = '0;

    // R7: write attempt in run must be ignored (would enable bit0)
    mask_we = 4'b0010; mask_d = 3'b111;
    tick;
    mask_we = '0;
    exc = 12'h008;                      // board1 bit0
    tick;
    exc = '0;
    chk("R6 R7 masked bit no halt", hreq, 0);
    tick;
    chk("R6 stays run", run, 4'hF);
    chk("R6 glb_halt low", ghalt, 0);

    halt_cycle("R5", 4'b0100, 4'b0000, 12'h000, 4'b0100);
    halt_cycle("R6 enabled bit", 4'b0000, 4'b0000, 12'h010, 4'b0010);
    halt_cycle("R8 host stop", 4'b0000, 4'b1000, 12'h000, 4'b1000);
    halt_cycle("R6 reset mask", 4'b0000, 4'b0000, 12'h004, 4'b0001);
    halt_cycle("R5 R8 mixed", 4'b0001, 4'b0100, 12'h000, 4'b0101);

    hold = 1'b1;
    tick;
    chk("R2 host hold", ghalt, 1);
    chk("R3 run one more", run, 4'hF);
    tick;
    chk("R3 halted by hold", run, 0);
    hold = 1'b0;
    tick;
    tick;
    chk("R4 resume after hold", run, 4'hF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule